// File: doc/BRIEF.md
# Nibble-Command Memory Bus Master

This block lets a host drive single-word reads and writes on a memory-mapped bus through a plain byte link, such as a serial port or a USB parallel FIFO. Each byte splits into two halves: a command in the high half and one data nibble in the low half. Load commands shift nibbles into an internal 32-bit address register or a 32-bit write-data register. Action commands then start one bus write or one bus read.

The bus master holds its request until the slave drops its wait request. A read word goes back to the host as eight response bytes. Each of these bytes carries one nibble of the word and a fixed marker in its upper half. While a transaction or its response is still in progress, the block refuses new input bytes. The host can therefore stream commands without pacing them.

Top module: `nib_bus_master`

## Requirements
- R1: A byte's command is bits [7:4] and its nibble is bits [3:0]. Command codes 0x8 to 0xF are ignored. Such a byte leaves the address and write-data registers unchanged, starts no bus cycle and produces no response.
- R2: Code 0x1 shifts the address register left by 4 and puts the nibble in bits [3:0]. After eight such bytes the register holds a full 32-bit address, and older nibbles shift out at the top.
- R3: Code 0x2 shifts the nibble into the write-data register in the same way as R2.
- R4: Code 0x3 issues exactly one bus write of the current write data to the current address and leaves both registers unchanged. The nibble of this byte is ignored.
- R5: Code 0x4 behaves as R4, and the address register then increases by 4 once the write completes.
- R6: Code 0x5 first shifts its nibble into the write-data register and then writes the resulting value, without changing the address.
- R7: Code 0x6 issues one bus read. Code 0x7 does the same, and the address then increases by 4. The read word is returned as eight bytes, most significant nibble first, each byte being {0xA, nibble}.
- R8: Code 0x0 clears both the address and the write-data registers.
- R9: The read and write strobes are never high together. While a strobe is high and wait request is high, the strobe, the address and the write data stay stable. A strobe rises in the cycle after its command byte is accepted. It stays high for (wait cycles + 1) cycles. Input ready is low from the command byte until the transaction and any response are finished.
- R10: A response byte whose output ready is low stays valid and unchanged until it is taken.
- R11: A synchronous active-high reset clears both registers, drops both strobes, discards any pending response and leaves input ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Command byte from the link |
| in_valid | input | 1 | Command byte present |
| in_ready | output | 1 | Block can take a command byte |
| out_data | output | 8 | Response byte to the link |
| out_valid | output | 1 | Response byte present |
| out_ready | input | 1 | Link takes the response byte |
| bus_addr | output | 32 | Bus address (current address register) |
| bus_wdata | output | 32 | Bus write data (current write-data register) |
| bus_write | output | 1 | Write request |
| bus_read | output | 1 | Read request |
| bus_rdata | input | 32 | Read data, valid when a read completes |
| bus_waitreq | input | 1 | Slave stall; a request completes at the first edge where it is low |

## Verification
A load or clear byte changes the address and data ports at the edge that accepts it, so the bench reads them at the following falling edge. An action byte raises its strobe one cycle after acceptance. The bench's slave holds wait request for a chosen number of cycles, so the bench counts the strobe-high cycles and expects wait + 1. The address increment appears at the completing edge. The first response byte is valid in the cycle after a read completes, and each later byte follows one cycle after the previous one is taken. Input ready returns one cycle after the last byte, so the bench always waits on ready or valid at falling edges rather than at fixed offsets.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        OP_NONE, OP_CLR, OP_LDA, OP_LDD, OP_WR, OP_WRI, OP_WRN, OP_RD, OP_RDI
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_WR, ST_RD, ST_RESP
    } st_e;
endpackage

// File: rtl/nbm_cmd_decode.sv
module nbm_cmd_decode
    import nbm_pkg::*;
(
    input  logic [2*NIB_W-1:0] byte_i,
    output op_e                op_o,
    output logic [NIB_W-1:0]   nib_o
);
    always_comb begin
        nib_o = byte_i[NIB_W-1:0];
        case (byte_i[2*NIB_W-1:NIB_W])
            4'h0:    op_o = OP_CLR;
            4'h1:    op_o = OP_LDA;
            4'h2:    op_o = OP_LDD;
            4'h3:    op_o = OP_WR;
            4'h4:    op_o = OP_WRI;
            4'h5:    op_o = OP_WRN;
            4'h6:    op_o = OP_RD;
            4'h7:    op_o = OP_RDI;
            default: op_o = OP_NONE;
        endcase
    end
endmodule

// File: rtl/nbm_resp_ser.sv
module nbm_resp_ser
    import nbm_pkg::*;
#(
    parameter int               DATA_W = 32,
    parameter logic [NIB_W-1:0] TAG    = 4'hA
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [DATA_W-1:0]    word_i,
    output logic [2*NIB_W-1:0]   out_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 busy_o
);
    localparam int N  = DATA_W / NIB_W;
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     cnt;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.sh  = word_i;
            s_d.cnt = CW'(N);
        end else if (s_q.cnt != '0 && out_ready) begin
            s_d.sh  = s_q.sh << NIB_W;
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = (s_q.cnt != '0);
    assign out_data  = {TAG, s_q.sh[DATA_W-1 -: NIB_W]};
    assign busy_o    = out_valid;
endmodule

// File: rtl/nib_bus_master.sv
module nib_bus_master
    import nbm_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter int               DATA_W    = 32,
    parameter int               ADDR_STEP = 4,
    parameter logic [NIB_W-1:0] RESP_TAG  = 4'hA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_write,
    output logic              bus_read,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_waitreq
);
    typedef struct packed {
        st_e               st;
        logic              inc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
    } reg_t;

    reg_t             r_d, r_q;
    op_e              op;
    logic [NIB_W-1:0] nib;
    logic             ser_load;
    logic             ser_busy;

    nbm_cmd_decode u_dec (
        .byte_i (in_data),
        .op_o   (op),
        .nib_o  (nib)
    );

    nbm_resp_ser #(.DATA_W(DATA_W), .TAG(RESP_TAG)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ser_load),
        .word_i    (bus_rdata),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .busy_o    (ser_busy)
    );

    always_comb begin
        r_d      = r_q;
        ser_load = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    case (op)
                        OP_CLR: begin
                            r_d.addr = '0;
                            r_d.wd   = '0;
                        end
                        OP_LDA: r_d.addr = {r_q.addr[ADDR_W-NIB_W-1:0], nib};
                        OP_LDD: r_d.wd   = {r_q.wd[DATA_W-NIB_W-1:0], nib};
                        OP_WR: begin
                            r_d.st  = ST_WR;
                            r_d.inc = 1'b0;
                        end
                        OP_WRI: begin
                            r_d.st  = ST_WR;
                            r_d.inc = 1'b1;
                        end
                        OP_WRN: begin
                            r_d.wd  = {r_q.wd[DATA_W-NIB_W-1:0], nib};
                            r_d.st  = ST_WR;
                            r_d.inc = 1'b0;
                        end
                        OP_RD: begin
                            r_d.st  = ST_RD;
                            r_d.inc = 1'b0;
                        end
                        OP_RDI: begin
                            r_d.st  = ST_RD;
                            r_d.inc = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WR: begin
                if (!bus_waitreq) begin
                    r_d.st = ST_IDLE;
                    if (r_q.inc) r_d.addr = r_q.addr + ADDR_W'(ADDR_STEP);
                end
            end
            ST_RD: begin
                if (!bus_waitreq) begin
                    ser_load = 1'b1;
                    r_d.st   = ST_RESP;
                    if (r_q.inc) r_d.addr = r_q.addr + ADDR_W'(ADDR_STEP);
                end
            end
            ST_RESP: begin
                if (!ser_busy) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.inc  <= 1'b0;
            r_q.addr <= '0;
            r_q.wd   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_IDLE);
    assign bus_write = (r_q.st == ST_WR);
    assign bus_read  = (r_q.st == ST_RD);
    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.wd;
endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic [7:0]        out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_write,
    input logic              bus_read,
    input logic              bus_waitreq
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_read && bus_write)); // R9

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        (bus_read || bus_write) && bus_waitreq |=>
        $stable(bus_read) && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata)); // R9

    AST_BUSY_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
        (bus_read || bus_write || out_valid) |-> !in_ready); // R9

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

    AST_RESP_MARK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data[7:4] == 4'hA); // R7

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bus_read && !bus_write && !out_valid && in_ready
                       && bus_addr == '0 && bus_wdata == '0); // R11
endmodule

bind nib_bus_master nbm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_write   (bus_write),
    .bus_read    (bus_read),
    .bus_waitreq (bus_waitreq)
);

// File: tb/sim_nib_bus_master.sv
module sim_nib_bus_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_write, bus_read, bus_waitreq;

    int          n_chk = 0;
    int          n_bad = 0;
    int          wait_n = 2;
    int          wcnt = 0;
    int          n_wr = 0;
    logic        done = 1'b0;
    logic [31:0] mem [16];

    always #2.5 clk = ~clk;

    nib_bus_master u0 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write), .bus_read(bus_read),
        .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq)
    );

    // bench slave: 16 words, wait request held for wait_n cycles
    assign bus_waitreq = (bus_read || bus_write) && (wcnt < wait_n);
    assign bus_rdata   = mem[bus_addr[5:2]];
    always_ff @(posedge clk) begin
        if ((bus_read || bus_write) && bus_waitreq) wcnt <= wcnt + 1;
        else                                        wcnt <= 0;
        if (bus_write && !bus_waitreq) begin
            mem[bus_addr[5:2]] <= bus_wdata;
            n_wr <= n_wr + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
    endtask

    task automatic collect(output logic [63:0] got);
        for (int i = 0; i < 8; i++) begin
            while (!out_valid) @(negedge clk);
            got = {got[55:0], out_data};
            @(negedge clk);
        end
    endtask

    // {byte, expected address, expected write data}
    localparam logic [71:0] VEC [12] = '{
        {8'h11, 32'h0000_0001, 32'h0000_0000},  // R2
        {8'h12, 32'h0000_0012, 32'h0000_0000},  // R2
        {8'h2A, 32'h0000_0012, 32'h0000_000A},  // R3
        {8'h2B, 32'h0000_0012, 32'h0000_00AB},  // R3
        {8'h80, 32'h0000_0012, 32'h0000_00AB},  // R1 ignored
        {8'h13, 32'h0000_0123, 32'h0000_00AB},  // R2
        {8'h00, 32'h0000_0000, 32'h0000_0000},  // R8
        {8'h14, 32'h0000_0004, 32'h0000_0000},  // R2
        {8'h27, 32'h0000_0004, 32'h0000_0007},  // R3
        {8'h40, 32'h0000_0008, 32'h0000_0007},  // R5
        {8'h59, 32'h0000_0008, 32'h0000_0079},  // R6
        {8'h3F, 32'h0000_0008, 32'h0000_0079}   // R4
    };

    initial begin
        logic [63:0] got;
        int          hi;
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        mem[3] = 32'h1234_ABCD;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset ready", {31'd0, in_ready}, 32'd1);
        check("R11 reset addr", bus_addr, 32'd0);
        check("R11 reset valid", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < 12; i++) begin
            send(VEC[i][71:64]);
            wait_idle();
            check("R1-table addr", VEC[i][63:32], bus_addr);
            check("R1-table wdata", VEC[i][31:0], bus_wdata);
        end
        check("R4 write count", n_wr, 3);
        check("R5 mem at 4", mem[1], 32'h7);
        check("R6 mem at 8", mem[2], 32'h79);

        // R1: ignored code starts no bus cycle and no response
        send(8'hF6);
        check("R1 no strobe", {30'd0, bus_read, bus_write}, 32'd0);
        check("R1 no response", {31'd0, out_valid}, 32'd0);

        // R2: full 32-bit load then one more shifts out the top nibble
        send(8'h1D); send(8'h1E); send(8'h1A); send(8'h1D);
        send(8'h1B); send(8'h1E); send(8'h1E); send(8'h1F);
        check("R2 full addr", bus_addr, 32'hDEAD_BEEF);
        send(8'h11);
        check("R2 shift out", bus_addr, 32'hEADB_EEF1);

        // R9: strobe timing and duration under wait request
        wait_n = 3;
        send(8'h00); send(8'h2C);
        send(8'h30);
        check("R9 strobe next cycle", {31'd0, bus_write}, 32'd1);
        hi = 0;
        while (bus_write) begin
            check("R9 ready low", {31'd0, in_ready}, 32'd0);
            hi++;
            @(negedge clk);
        end
        check("R9 strobe cycles", hi, 4);
        check("R4 data written", mem[0], 32'hC);

        // R7 + R10: read with increment, stalled response
        wait_n = 1;
        send(8'h00); send(8'h1C);
        out_ready = 1'b0;
        send(8'h70);
        while (!out_valid) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check("R10 held byte", {24'd0, out_data}, 32'hA1);
            @(negedge clk);
        end
        check("R7 addr incremented", bus_addr, 32'h10);
        out_ready = 1'b1;
        collect(got);
        check("R7 bytes hi", got[63:32], 32'hA1A2_A3A4);
        check("R7 bytes lo", got[31:0], 32'hAAAB_ACAD);
        @(negedge clk);
        check("R9 ready after resp", {31'd0, in_ready}, 32'd1);

        // R7: plain read keeps address
        send(8'h00); send(8'h1C);
        send(8'h60);
        collect(got);
        check("R7 plain read", got[63:32], 32'hA1A2_A3A4);
        check("R7 addr kept", bus_addr, 32'hC);

        // R11: reset while a response is pending
        out_ready = 1'b0;
        send(8'h2E);
        send(8'h60);
        while (!out_valid) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 resp dropped", {31'd0, out_valid}, 32'd0);
        check("R11 ready", {31'd0, in_ready}, 32'd1);
        check("R11 addr clear", bus_addr, 32'd0);
        check("R11 data clear", bus_wdata, 32'd0);
        check("R11 strobes low", {30'd0, bus_read, bus_write}, 32'd0);
        repeat (3) @(negedge clk);
        check("R11 stays idle", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule